// File: doc/BRIEF.md
# Serial Converter Frame Reader

This block is a host-side master for a three-wire serial analog-to-digital converter. It runs on the system clock and derives the converter's chip select and serial clock from it. Each accepted start request runs one frame. Chip select goes low and sixteen serial clock pulses are issued. The data line is captured on every falling clock edge, and the first twelve bits captured become the sample.

After the sixteenth falling edge, chip select stays low for a guard interval so the converter can finish its internal conversion. Chip select then rises, the twelve-bit value is presented with a one-cycle valid strobe, and one extra serial clock pulse is issued while chip select is high. The converter needs that pulse between frames.

A converter of this kind returns in each frame the sample taken during the frame before. For that reason the first result after reset carries a flag that marks it as stale. The serial clock rate and the guard interval are set by parameters in nanoseconds and hertz and converted to whole system-clock cycles.

Top module: `spi_adc_reader`

## Requirements
- R1: `sclk` idles low. It is low in every cycle where `cs_n` changes level, and low whenever no frame is running.
- R2: Each frame holds `cs_n` low across exactly 16 falling edges of `sclk`.
- R3: `sdo_in` is captured on each falling edge of `sclk`. The first captured bit is the MSB of `result`, and the first 12 captured bits form `result`. Bits 13 to 16 are discarded.
- R4: `cs_n` rises exactly G system cycles after the 16th falling edge of `sclk`, where G = ceil(GUARD_NS * CLK_HZ / 1e9), with a minimum of 1.
- R5: Between the rise of `cs_n` and the next fall of `cs_n`, exactly one falling edge of `sclk` occurs.
- R6: `result_valid` is high for exactly one cycle, and that cycle is the cycle in which `cs_n` has just risen.
- R7: `result_stale` is 1 alongside the first result after reset and 0 alongside every later result.
- R8: Each high phase of `sclk` lasts H system cycles, where H = max(SCLK_HALF, ceil(CLK_HZ / (2 * MAX_SCLK_HZ))). This keeps the serial clock at or below MAX_SCLK_HZ.
- R9: `start` is ignored unless the block is idle. A request during shifting, during the guard interval or during the inter-frame pulse starts no frame.
- R10: After reset, `cs_n`=1, `sclk`=0, `result_valid`=0, `result`=0 and `result_stale`=0.
- R11: The first rising edge of `sclk` in a frame comes exactly H system cycles after `cs_n` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one read frame; honoured only when idle |
| sdo_in | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select to the converter |
| sclk | output | 1 | Serial clock to the converter |
| result | output | DATA_BITS | Last captured sample |
| result_valid | output | 1 | One-cycle strobe when a new result is presented |
| result_stale | output | 1 | Marks the first result after reset |

## Verification
The bench builds the block with CLK_HZ = 50 MHz, MAX_SCLK_HZ = 20 MHz, SCLK_HALF = 1 and GUARD_NS = 3510.

The requested half period of one cycle is below the rate limit, so the clamp must raise it to two cycles. The guard interval works out to 175.5 cycles, so its round-up to 176 is observable.

These small values keep each frame near 250 cycles. That makes a few dozen random words affordable, together with start requests placed in every busy phase and a reset in the middle of the run.

// File: rtl/spi_adc_reader.sv
module spi_adc_reader #(
  parameter int CLK_HZ      = 50_000_000,
  parameter int MAX_SCLK_HZ = 20_000_000,
  parameter int SCLK_HALF   = 4,
  parameter int GUARD_NS    = 3500,
  parameter int FRAME_BITS  = 16,
  parameter int DATA_BITS   = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 sdo_in,
  output logic                 cs_n,
  output logic                 sclk,
  output logic [DATA_BITS-1:0] result,
  output logic                 result_valid,
  output logic                 result_stale
);

  localparam longint HALF_MIN_L = (longint'(CLK_HZ) + 2 * longint'(MAX_SCLK_HZ) - 1)
                                  / (2 * longint'(MAX_SCLK_HZ));
  localparam int     HALF       = (longint'(SCLK_HALF) < HALF_MIN_L) ? int'(HALF_MIN_L) : SCLK_HALF;
  localparam longint GUARD_L    = (longint'(GUARD_NS) * longint'(CLK_HZ) + 64'd999_999_999)
                                  / 64'd1_000_000_000;
  localparam int     GUARD      = (GUARD_L < 1) ? 1 : int'(GUARD_L);
  localparam int     TMAX       = (HALF > GUARD) ? HALF : GUARD;
  localparam int     TW         = $clog2(TMAX + 1);
  localparam int     NW         = $clog2(FRAME_BITS + 1);
  localparam logic [TW-1:0] HALF_M1  = TW'(HALF - 1);
  localparam logic [TW-1:0] GUARD_M1 = TW'(GUARD - 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_HIGH, ST_LOW, ST_GUARD, ST_GAP, ST_PULSE
  } state_t;

  state_t               st;
  logic [TW-1:0]        tmr;
  logic [NW-1:0]        nbits;
  logic [DATA_BITS-1:0] shreg;
  logic                 seen;

  wire tick = (tmr == '0);
  wire last = (nbits == NW'(FRAME_BITS - 1));
  wire keep = (nbits < NW'(DATA_BITS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= ST_IDLE;
      tmr          <= '0;
      nbits        <= '0;
      shreg        <= '0;
      seen         <= 1'b0;
      cs_n         <= 1'b1;
      sclk         <= 1'b0;
      result       <= '0;
      result_valid <= 1'b0;
      result_stale <= 1'b0;
    end else begin
      result_valid <= 1'b0;
      if (!tick) tmr <= tmr - 1'b1;
      case (st)
        ST_IDLE: if (start) begin
          cs_n  <= 1'b0;
          nbits <= '0;
          tmr   <= HALF_M1;
          st    <= ST_LEAD;
        end
        ST_LEAD, ST_LOW: if (tick) begin
          sclk <= 1'b1;
          tmr  <= HALF_M1;
          st   <= ST_HIGH;
        end
        ST_HIGH: if (tick) begin
          sclk  <= 1'b0;
          nbits <= nbits + 1'b1;
          if (keep) shreg <= {shreg[DATA_BITS-2:0], sdo_in};
          if (last) begin
            tmr <= GUARD_M1;
            st  <= ST_GUARD;
          end else begin
            tmr <= HALF_M1;
            st  <= ST_LOW;
          end
        end
        ST_GUARD: if (tick) begin
          cs_n         <= 1'b1;
          result       <= shreg;
          result_valid <= 1'b1;
          result_stale <= !seen;
          seen         <= 1'b1;
          tmr          <= HALF_M1;
          st           <= ST_GAP;
        end
        ST_GAP: if (tick) begin
          sclk <= 1'b1;
          tmr  <= HALF_M1;
          st   <= ST_PULSE;
        end
        ST_PULSE: if (tick) begin
          sclk <= 1'b0;
          st   <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_cs_edge_sclk_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cs_n) || $fell(cs_n)) |-> !sclk);

  assert_sixteen_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (nbits == NW'(FRAME_BITS)));

  assert_guard_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_GUARD) |-> (!sclk && !cs_n));

  assert_idle_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && $past(st) == ST_PULSE) |-> ($fell(sclk) && cs_n));

  assert_valid_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> $rose(cs_n));

  assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);

  assert_half_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_HIGH || st == ST_LOW) && !tick) |=> $stable(sclk));

  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE && cs_n && start) |=> cs_n);

endmodule

// File: tb/spi_adc_reader_tb.sv
module spi_adc_reader_tb;
  localparam int CLK_HZ = 50_000_000;
  localparam int MAXF   = 20_000_000;
  localparam int SHALF  = 1;
  localparam int GNS    = 3510;

  function automatic int exp_half();
    int m = (CLK_HZ + 2 * MAXF - 1) / (2 * MAXF);
    return (SHALF > m) ? SHALF : m;
  endfunction

  function automatic int exp_guard();
    longint g = (longint'(GNS) * CLK_HZ + 999_999_999) / 1_000_000_000;
    return (g < 1) ? 1 : int'(g);
  endfunction

  logic clk = 0, rst_n = 0, start = 0, sdo_in = 0;
  logic cs_n, sclk, result_valid, result_stale;
  logic [11:0] result;

  spi_adc_reader #(.CLK_HZ(CLK_HZ), .MAX_SCLK_HZ(MAXF), .SCLK_HALF(SHALF), .GUARD_NS(GNS))
    u_dut (.clk(clk), .rst_n(rst_n), .start(start), .sdo_in(sdo_in), .cs_n(cs_n),
           .sclk(sclk), .result(result), .result_valid(result_valid),
           .result_stale(result_stale));

  always #10 clk = ~clk;

  int tests = 0, fails = 0;
  int cyc = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // converter model: MSB on cs fall, next bit on each rise after the first
  logic [15:0] word = 16'h0;
  int rc = 0;
  always @(negedge cs_n or posedge sclk) begin
    if (!cs_n) begin
      if (!sclk) begin rc = 0; sdo_in = word[15]; end
      else begin
        if (rc < 16) sdo_in = word[15 - rc];
        rc++;
      end
    end
  end

  // edge monitor sampled at the falling clock edge
  logic p_cs = 1, p_sclk = 0, p_val = 0;
  int falls_in = 0, falls_out = 0, last_fall = 0, hi_len = 0, cs_fall_cyc = 0;
  bit have_prev = 0, first_rise = 0;
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      have_prev = 0; falls_out = 0; p_cs = 1; p_sclk = 0; p_val = 0;
    end else begin
      if (sclk) hi_len++;
      if (p_cs && !cs_n) begin
        chk(sclk == 0, "R1 sclk at cs fall", sclk, 0);
        if (have_prev) chk(falls_out == 1, "R5 idle pulse count", falls_out, 1);
        falls_in = 0; cs_fall_cyc = cyc; first_rise = 1;
      end
      if (!p_sclk && sclk && !cs_n && first_rise) begin
        chk(cyc - cs_fall_cyc == exp_half(), "R11 lead time", cyc - cs_fall_cyc, exp_half());
        first_rise = 0;
      end
      if (p_sclk && !sclk) begin
        chk(hi_len == exp_half(), "R8 high phase", hi_len, exp_half());
        if (!cs_n) begin falls_in++; last_fall = cyc; end
        else falls_out++;
      end
      if (!sclk) hi_len = 0;
      if (!p_cs && cs_n) begin
        chk(sclk == 0, "R1 sclk at cs rise", sclk, 0);
        chk(falls_in == 16, "R2 falls per frame", falls_in, 16);
        chk(cyc - last_fall == exp_guard(), "R4 guard cycles", cyc - last_fall, exp_guard());
        falls_out = 0; have_prev = 1;
      end
      if (result_valid) chk(!p_cs == 0 ? 0 : cs_n == 1, "R6 valid with cs rise", p_cs, 0);
      if (result_valid && p_val) chk(0, "R6 valid width", 2, 1);
      p_cs = cs_n; p_sclk = sclk; p_val = result_valid;
    end
  end

  task automatic wait_valid();
    int t = 0;
    do begin @(negedge clk); t++; end while (!result_valid && t < 2000);
    chk(t < 2000, "R6 valid arrives", t, 0);
  endtask

  task automatic frame(input logic [15:0] w, input bit want_stale, input bit poke);
    word = w;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    if (poke) begin
      repeat (20) @(negedge clk);
      start = 1; @(negedge clk) start = 0;
      repeat (80) @(negedge clk);
      start = 1; @(negedge clk) start = 0;
    end
    wait_valid();
    chk(result == w[15:4], "R3 result", result, w[15:4]);
    chk(result_stale == want_stale, "R7 stale flag", result_stale, want_stale);
    if (poke) begin
      @(negedge clk) start = 1;
      @(negedge clk) start = 0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (!cs_n) chk(0, "R9 start while busy", 0, 1);
      end
      chk(cs_n == 1, "R9 no frame from busy start", cs_n, 1);
    end
    repeat (6 + ($urandom % 20)) @(negedge clk);
    chk(sclk == 0 && cs_n == 1, "R1 idle levels", {cs_n, sclk}, 2);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(cs_n == 1 && sclk == 0, "R10 reset pins", {cs_n, sclk}, 2);
    chk(result_valid == 0 && result == 0 && result_stale == 0, "R10 reset outputs",
        result, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    frame(16'hA5C3, 1, 0);
    frame(16'hFFFF, 0, 1);
    frame(16'h000F, 0, 0);
    frame(16'h8000, 0, 0);
    frame(16'h0010, 0, 1);
    for (int k = 0; k < 20; k++) frame(16'($urandom), 0, (k % 7) == 3);
    @(negedge clk) rst_n = 0;
    @(negedge clk);
    chk(cs_n == 1 && sclk == 0 && result == 0, "R10 reset mid run", result, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    frame(16'h5A3C, 1, 0);
    frame(16'h1234, 0, 0);
    for (int k = 0; k < 8; k++) frame(16'($urandom), 0, 0);
    done = 1;
  end

  initial begin
    while (!done && cyc < 190_000) @(negedge clk);
    if (!done) chk(0, "watchdog", cyc, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule